// File: doc/BRIEF.md
# 16-bit Prescaled Timer with Phase-Correct PWM

This block is a 16-bit timer/counter that runs from a divided version of the system clock and drives one compare output. A prescaler gives a counting tick on every clock, or on every 8th, 64th, 256th or 1024th clock. The counter can also be stopped. Three counting modes are offered. Free-running mode wraps from all-ones to zero. Clear-on-match mode returns to zero when the count equals the compare value. Phase-correct PWM counts up from zero to a TOP of 255, 511 or 1023 and then back down.

Software-style write strobes load the counter and the compare value, and the current values are always visible on read ports. In PWM mode a compare write lands in a holding register, and the holding register moves to the live compare value when the counter turns at TOP. Compare and overflow events come out as one-cycle strobes. The output pin is driven by a 2-bit action code and keeps its internal level while it is disconnected. All pins are plain control and status pins; there is no streaming interface.

Top module: `pwm_timer16`

## Requirements
- R1: `clk_sel` picks the counting tick: 0 or 6-7 stopped, 1 every clock, 2 every 8th, 3 every 64th, 4 every 256th, 5 every 1024th. A tick occurs on the clock where the prescaler count, which restarts at 0 after a cycle with `psc_clr` high, has its low log2(N) bits all ones. A cycle with `psc_clr` high gives no tick.
- R2: `mode` 0 is free-running: each tick adds one. A tick taken at 0xFFFF wraps the counter to 0 and pulses `ovf_evt` in the following cycle.
- R3: `mode` 1 is clear-on-match. A match is taken on the tick that ends a count equal to the compare value, so with divide-by-8 the counter holds that value for 8 clocks. That tick loads 0 and pulses `cmp_evt` in the cycle where `cnt_q` first reads 0.
- R4: `mode` 2, 3, 4 select phase-correct PWM with TOP 0x00FF, 0x01FF or 0x03FF. The counter counts up to TOP, then down to 0, then up again. The tick taken at 0 while counting down pulses `ovf_evt`.
- R5: In PWM mode, counter bits above the resolution are held at zero, including on a `cnt_wr` write. For example, 0x0123 written at 8-bit resolution reads back as 0x0023.
- R6: In PWM mode, compare bits above the resolution are cleared. For example, 0xFFFF written at 8-bit resolution becomes 0x00FF once it is live.
- R7: In PWM mode, `cmp_wr` loads a holding register, and `cmp_q` keeps the old live value until a tick taken at TOP while counting up copies the holding register across. In the other modes, a write updates the live value in the next cycle.
- R8: `cmp_q` always shows the live compare value. If PWM mode is left before the copy at TOP, the pending value is never shown.
- R9: `com` 01 toggles the pin on a match outside PWM mode. `com` 10 clears it on a match outside PWM. In PWM, `com` 10 clears it on an up-count match and sets it on a down-count match. `com` 11 is the inverse of 10 in both cases. `com` 00, and `com` 01 in PWM, disconnect the pin, and `oc_pin` then reads 0.
- R10: While the pin is disconnected, matches leave its internal level untouched. On reconnection, `oc_pin` resumes the level it had.
- R11: While `rst_n` is low, `cnt_q`, `cmp_q`, `oc_pin`, `cmp_evt` and `ovf_evt` are all 0.
- R12: A `cnt_wr` write takes priority over a tick in the same cycle. That tick produces no match, no overflow and no buffer copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psc_clr | input | 1 | Synchronous prescaler restart |
| clk_sel | input | 3 | Tick source select |
| mode | input | 3 | Counting mode |
| com | input | 2 | Compare output action |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write value |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | 16 | Compare write value |
| cnt_q | output | 16 | Current count |
| cmp_q | output | 16 | Live compare value |
| cmp_evt | output | 1 | One-cycle compare match strobe |
| ovf_evt | output | 1 | One-cycle overflow strobe |
| oc_pin | output | 1 | Compare output pin |

## Verification
Every result is registered once. A tick, write or match at one clock edge shows up on `cnt_q`, `cmp_q`, `cmp_evt`, `ovf_evt` and the pin state after that same edge. The exception is a PWM compare write, which reaches `cmp_q` only after the later edge at TOP. `oc_pin` also follows a change of `com` or `mode` without any clock delay. The bench drives inputs and samples outputs at the falling edge, and a cycle model that advances at each rising edge predicts every output for the next falling-edge sample. The directed cases count clocks explicitly, for example the 8 samples at the compare value before a clear at divide-by-8.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [2:0] {
    MODE_FREE  = 3'd0,
    MODE_CLR   = 3'd1,
    MODE_PWM8  = 3'd2,
    MODE_PWM9  = 3'd3,
    MODE_PWM10 = 3'd4
  } mode_e;

  function automatic logic is_pwm(input logic [2:0] m);
    return (m == MODE_PWM8) || (m == MODE_PWM9) || (m == MODE_PWM10);
  endfunction

  function automatic logic pin_linked(input logic [2:0] m, input logic [1:0] c);
    return is_pwm(m) ? c[1] : (c != 2'b00);
  endfunction
endpackage

// File: rtl/pt_prescaler.sv
module pt_prescaler #(
  parameter int PW = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (clr) div_q <= '0;
    else          div_q <= div_q + 1'b1;
  end

  always_comb begin
    unique case (sel)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &div_q[2:0];
      3'd3:    tick = &div_q[5:0];
      3'd4:    tick = &div_q[7:0];
      3'd5:    tick = &div_q[9:0];
      default: tick = 1'b0;
    endcase
    if (clr) tick = 1'b0;
  end
endmodule

// File: rtl/pt_counter.sv
module pt_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [2:0]    mode,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] ocr,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] mask,
  output logic          down,
  output logic          match,
  output logic          top_hit,
  output logic          cmp_evt,
  output logic          ovf_evt
);
  import pt_pkg::*;

  localparam logic [CW-1:0] ONES = '1;
  localparam logic [CW-1:0] M8   = {{(CW-8){1'b0}}, {8{1'b1}}};
  localparam logic [CW-1:0] M9   = {{(CW-9){1'b0}}, {9{1'b1}}};
  localparam logic [CW-1:0] M10  = {{(CW-10){1'b0}}, {10{1'b1}}};

  logic [CW-1:0] cnt_q, cnt_n;
  logic          dn_q, dn_n, ovf_n, live, pwm;

  always_comb begin
    unique case (mode)
      MODE_PWM8:  mask = M8;
      MODE_PWM9:  mask = M9;
      MODE_PWM10: mask = M10;
      default:    mask = ONES;
    endcase
  end

  assign pwm     = is_pwm(mode);
  assign live    = tick & ~wr;
  assign match   = live & (cnt_q == ocr);
  assign top_hit = live & pwm & ~dn_q & (cnt_q >= mask);

  always_comb begin
    cnt_n = cnt_q;
    dn_n  = pwm ? dn_q : 1'b0;
    ovf_n = 1'b0;
    if (wr) begin
      cnt_n = wdata;
    end else if (tick) begin
      if (pwm) begin
        if (!dn_q) begin
          if (cnt_q >= mask) begin
            dn_n  = 1'b1;
            cnt_n = mask - 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end else if (cnt_q == '0) begin
          dn_n  = 1'b0;
          cnt_n = {{(CW-1){1'b0}}, 1'b1};
          ovf_n = 1'b1;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end else begin
        cnt_n = (mode == MODE_CLR && match) ? '0 : cnt_q + 1'b1;
        ovf_n = (cnt_q == ONES);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      dn_q    <= 1'b0;
      cmp_evt <= 1'b0;
      ovf_evt <= 1'b0;
    end else begin
      cnt_q   <= cnt_n & mask;
      dn_q    <= dn_n;
      cmp_evt <= match;
      ovf_evt <= ovf_n;
    end
  end

  assign cnt  = cnt_q;
  assign down = dn_q;
endmodule

// File: rtl/pt_compare.sv
module pt_compare #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm,
  input  logic [CW-1:0] mask,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic          top_hit,
  output logic [CW-1:0] ocr
);
  logic [CW-1:0] hold_q, act_q, act_n;

  always_comb begin
    act_n = act_q;
    if (top_hit)    act_n = hold_q;
    if (wr && !pwm) act_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr) hold_q <= pwm ? (wdata & mask) : wdata;
      act_q <= act_n & mask;
    end
  end

  assign ocr = act_q;
endmodule

// File: rtl/pt_outpin.sv
module pt_outpin (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic [1:0] com,
  input  logic       match,
  input  logic       down,
  output logic       pin
);
  import pt_pkg::*;

  logic state_q, state_n, linked;

  assign linked = pin_linked(mode, com);

  always_comb begin
    state_n = state_q;
    if (match && linked) begin
      if (is_pwm(mode)) state_n = com[0] ^ down;
      else if (com == 2'b01) state_n = ~state_q;
      else state_n = com[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= 1'b0;
    else        state_q <= state_n;
  end

  assign pin = linked & state_q;
endmodule

// File: rtl/pwm_timer16.sv
module pwm_timer16 #(
  parameter int CW = 16,
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psc_clr,
  input  logic [2:0]    clk_sel,
  input  logic [2:0]    mode,
  input  logic [1:0]    com,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          cmp_wr,
  input  logic [CW-1:0] cmp_wdata,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cmp_q,
  output logic          cmp_evt,
  output logic          ovf_evt,
  output logic          oc_pin
);
  logic          tick, down, match, top_hit;
  logic [CW-1:0] mask, ocr;

  pt_prescaler #(.PW(PW)) u_psc (
    .clk(clk), .rst_n(rst_n), .clr(psc_clr), .sel(clk_sel), .tick(tick)
  );

  pt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
    .wr(cnt_wr), .wdata(cnt_wdata), .ocr(ocr),
    .cnt(cnt_q), .mask(mask), .down(down), .match(match),
    .top_hit(top_hit), .cmp_evt(cmp_evt), .ovf_evt(ovf_evt)
  );

  pt_compare #(.CW(CW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .pwm(pt_pkg::is_pwm(mode)), .mask(mask),
    .wr(cmp_wr), .wdata(cmp_wdata), .top_hit(top_hit), .ocr(ocr)
  );

  pt_outpin u_pin (
    .clk(clk), .rst_n(rst_n), .mode(mode), .com(com),
    .match(match), .down(down), .pin(oc_pin)
  );

  assign cmp_q = ocr;
endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    clk_sel,
  input logic [2:0]    mode,
  input logic [1:0]    com,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] cmp_q,
  input logic          cmp_evt,
  input logic          ovf_evt,
  input logic          oc_pin,
  input logic          pin_state
);
  logic [CW-1:0] lim;
  always_comb begin
    case (mode)
      3'd2:    lim = CW'(255);
      3'd3:    lim = CW'(511);
      3'd4:    lim = CW'(1023);
      default: lim = '1;
    endcase
  end

  // R11
  always_comb begin
    if (!rst_n) pin_reset_chk: assert (oc_pin == 1'b0);
  end

  // R1
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0) |=> (!cmp_evt && !ovf_evt));

  // R3
  clr_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt && $past(mode) == 3'd1) |-> (cnt_q == '0));

  // R5
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == mode) |-> (cnt_q <= lim));

  // R6
  cmp_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == mode) |-> (cmp_q <= lim));

  // R4
  ovf_at_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> (cnt_q <= CW'(1)));

  // R10
  pin_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (com == 2'b00) |=> $stable(pin_state));
endmodule

bind pwm_timer16 pt_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .mode(mode), .com(com),
  .cnt_q(cnt_q), .cmp_q(cmp_q), .cmp_evt(cmp_evt), .ovf_evt(ovf_evt),
  .oc_pin(oc_pin), .pin_state(u_pin.state_q)
);

// File: tb/test_pwm_timer16.sv
module test_pwm_timer16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psc_clr = 1'b0;
  logic [2:0]  clk_sel = 3'd0;
  logic [2:0]  mode = 3'd0;
  logic [1:0]  com = 2'b00;
  logic        cnt_wr = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic        cmp_wr = 1'b0;
  logic [15:0] cmp_wdata = '0;
  logic [15:0] cnt_q, cmp_q;
  logic        cmp_evt, ovf_evt, oc_pin;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_timer16 i_pwm_timer16 (
    .clk(clk), .rst_n(rst_n), .psc_clr(psc_clr), .clk_sel(clk_sel),
    .mode(mode), .com(com), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .cnt_q(cnt_q), .cmp_q(cmp_q),
    .cmp_evt(cmp_evt), .ovf_evt(ovf_evt), .oc_pin(oc_pin)
  );

  // reference model built from the requirements
  logic [9:0]  m_psc;
  logic [15:0] m_cnt, m_hold, m_act;
  logic        m_dn, m_st, m_cev, m_oev;

  function automatic logic [15:0] lim_of(input logic [2:0] m);
    case (m)
      3'd2: return 16'h00FF;
      3'd3: return 16'h01FF;
      3'd4: return 16'h03FF;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic pwm_of(input logic [2:0] m);
    return (m >= 3'd2) && (m <= 3'd4);
  endfunction

  function automatic logic link_of(input logic [2:0] m, input logic [1:0] c);
    return pwm_of(m) ? c[1] : (c != 2'b00);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_psc = '0; m_cnt = '0; m_hold = '0; m_act = '0;
      m_dn = 0; m_st = 0; m_cev = 0; m_oev = 0;
    end else begin
      logic tk, mt, th, pw, dn_next, ov;
      logic [15:0] lim, c_next, a_next;
      case (clk_sel)
        3'd1: tk = 1;
        3'd2: tk = (m_psc[2:0] == 3'h7);
        3'd3: tk = (m_psc[5:0] == 6'h3F);
        3'd4: tk = (m_psc[7:0] == 8'hFF);
        3'd5: tk = (m_psc == 10'h3FF);
        default: tk = 0;
      endcase
      if (psc_clr) tk = 0;
      m_psc = psc_clr ? '0 : m_psc + 1'b1;
      pw  = pwm_of(mode);
      lim = lim_of(mode);
      mt  = tk && !cnt_wr && (m_cnt == m_act);
      th  = tk && !cnt_wr && pw && !m_dn && (m_cnt >= lim);
      dn_next = pw ? m_dn : 1'b0;
      c_next = m_cnt;
      ov = 0;
      if (cnt_wr) c_next = cnt_wdata;
      else if (tk) begin
        if (pw) begin
          if (!m_dn) begin
            if (m_cnt >= lim) begin dn_next = 1; c_next = lim - 16'd1; end
            else c_next = m_cnt + 16'd1;
          end else if (m_cnt == 0) begin
            dn_next = 0; c_next = 16'd1; ov = 1;
          end else c_next = m_cnt - 16'd1;
        end else begin
          c_next = (mode == 3'd1 && mt) ? 16'd0 : m_cnt + 16'd1;
          ov = (m_cnt == 16'hFFFF);
        end
      end
      if (mt && link_of(mode, com)) begin
        if (pw) m_st = com[0] ^ m_dn;
        else if (com == 2'b01) m_st = ~m_st;
        else m_st = com[0];
      end
      a_next = m_act;
      if (th) a_next = m_hold;
      if (cmp_wr && !pw) a_next = cmp_wdata;
      if (cmp_wr) m_hold = pw ? (cmp_wdata & lim) : cmp_wdata;
      m_act = a_next & lim;
      m_cnt = c_next & lim;
      m_dn  = dn_next;
      m_cev = mt;
      m_oev = ov;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (rst_n) begin
      chk("R1 R2 R3 R4 R5 R12 count", cnt_q, m_cnt);
      chk("R6 R7 R8 compare", cmp_q, m_act);
      chk("R3 R9 R12 match strobe", {15'd0, cmp_evt}, {15'd0, m_cev});
      chk("R2 R4 overflow strobe", {15'd0, ovf_evt}, {15'd0, m_oev});
      chk("R9 R10 pin", {15'd0, oc_pin}, {15'd0, link_of(mode, com) & m_st});
    end
    cnt_wr = 0; cmp_wr = 0; psc_clr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'h1234_5EED));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 count", cnt_q, 16'h0);
    chk("R11 compare", cmp_q, 16'h0);
    chk("R11 pin/strobes", {13'd0, oc_pin, cmp_evt, ovf_evt}, 16'h0);
    rst_n = 1;

    // R5 counter write masked at 8-bit PWM
    mode = 3'd2; cnt_wr = 1; cnt_wdata = 16'h0123;
    cyc();
    chk("R5 masked write", cnt_q, 16'h0023);

    // R7 buffered compare, R6 masked after copy
    clk_sel = 3'd1; cmp_wr = 1; cmp_wdata = 16'hFFFF;
    cyc();
    chk("R7 held until TOP", cmp_q, 16'h0000);
    n = 0;
    while (cmp_q == 16'h0 && n < 600) begin cyc(); n++; end
    chk("R6 live value masked", cmp_q, 16'h00FF);

    // R8 leave PWM before copy
    cmp_wr = 1; cmp_wdata = 16'h0040;
    cyc();
    mode = 3'd0;
    cyc();
    chk("R8 live value kept", cmp_q, 16'h00FF);

    // R3 clear after last matching count, divide by 8
    mode = 3'd1; clk_sel = 3'd2; cmp_wr = 1; cmp_wdata = 16'd2;
    cnt_wr = 1; cnt_wdata = 16'd0; psc_clr = 1;
    n = 0;
    for (int i = 0; i < 100 && !cmp_evt; i++) begin
      cyc();
      if (cnt_q == 16'd2) n++;
    end
    chk("R3 clear on strobe", cnt_q, 16'd0);
    chk("R3 clocks at match value", 16'(n), 16'd8);

    // R9 toggle, R10 level memory
    mode = 3'd0; clk_sel = 3'd0; com = 2'b01;
    cmp_wr = 1; cmp_wdata = 16'd5; cnt_wr = 1; cnt_wdata = 16'd5;
    cyc();
    clk_sel = 3'd1;
    cyc();
    chk("R9 toggle on match", {15'd0, oc_pin}, 16'd1);
    clk_sel = 3'd0; com = 2'b00;
    cyc();
    chk("R9 disconnected reads 0", {15'd0, oc_pin}, 16'd0);
    cnt_wr = 1; cnt_wdata = 16'd5; clk_sel = 3'd1;
    cyc();
    cyc();
    chk("R10 match while disconnected", {15'd0, cmp_evt}, 16'd1);
    com = 2'b01; clk_sel = 3'd0;
    cyc();
    chk("R10 level resumed", {15'd0, oc_pin}, 16'd1);

    // R2 wrap, R12 write priority
    clk_sel = 3'd1; cnt_wr = 1; cnt_wdata = 16'hFFFF;
    cyc();
    chk("R12 write value", cnt_q, 16'hFFFF);
    cyc();
    chk("R2 wrap to zero", cnt_q, 16'h0000);
    chk("R2 overflow strobe", {15'd0, ovf_evt}, 16'd1);
    clk_sel = 3'd0; cnt_wr = 1; cnt_wdata = 16'd5;
    cyc();
    clk_sel = 3'd1; cnt_wr = 1; cnt_wdata = 16'h0100;
    cyc();
    chk("R12 write beats tick", cnt_q, 16'h0100);
    chk("R12 no match on write", {15'd0, cmp_evt}, 16'd0);

    // constrained random run against the model
    for (int i = 0; i < 6000; i++) begin
      cyc();
      if ($urandom_range(99) < 2) mode = 3'($urandom_range(4));
      if ($urandom_range(99) < 2) clk_sel = 3'($urandom_range(7) < 5 ? 1 : $urandom_range(7));
      if ($urandom_range(99) < 3) com = 2'($urandom_range(3));
      if ($urandom_range(99) < 2) psc_clr = 1;
      if ($urandom_range(99) < 4) begin
        cmp_wr = 1;
        cmp_wdata = ($urandom_range(3) == 0) ? 16'($urandom) : 16'($urandom_range(1023));
      end
      if ($urandom_range(99) < 1) begin
        cnt_wr = 1;
        cnt_wdata = ($urandom_range(3) == 0) ? 16'hFFF0 + 16'($urandom_range(15))
                                             : 16'($urandom_range(1023));
      end
    end
    finish_run();
  end
endmodule